// File: doc/BRIEF.md
# Mailbox receive interrupt flag controller

The block keeps one sticky receive interrupt flag for each message mailbox and raises a single interrupt line toward the CPU. A flag is set when its mailbox reports a completed reception, the mailbox is set up for receive, and its interrupt mask bit is 1. The CPU reads the flags one byte at a time and clears them by writing ones. Writing zeros changes nothing.

The interrupt output is a pulse, not a level. A pulse is raised when the flag set goes from empty to non-empty. A pulse is also raised when a CPU clear removes at least one flag and leaves other flags still pending. This way an interrupt controller that only sees edges cannot miss work that is still outstanding. A mailbox that is set up for transmit never holds a flag, so it always reads as 0.

Top module: `rx_irq_flags`

## Requirements
- R1: After the active-low asynchronous reset, all flags read as 0 and `irq_o` is 0.
- R2: Flag n is set at the clock edge where `rx_done_i[n]`, `mask_i[n]` and receive direction (`dir_tx_i[n]`=0) all hold. When `mask_i[n]`=0, a receive event leaves flag n at 0 and raises no pulse.
- R3: While `dir_tx_i[n]`=1 (transmit), flag n reads as 0 and is dropped at the next edge. A receive event for that mailbox is ignored.
- R4: When the flags were all 0 and a flag gets set, `irq_o` is 1 for the clock cycle right after that edge and then returns to 0.
- R5: When at least one flag is already set, a further receive event records its flag but raises no pulse, unless a clear condition of R7 occurs in the same cycle.
- R6: A write with `wr_en_i`=1 clears each flag whose bit in `wdata_i` is 1. `addr_i`=0 selects flags 7..0 and `addr_i`=1 selects flags 15..8. A 0 bit leaves its flag unchanged, and the byte that is not addressed is unaffected.
- R7: A write that clears at least one set flag and leaves one or more flags set raises a pulse in the next cycle. A write that leaves no flags set raises no pulse.
- R8: When a receive event and a clear hit the same flag in the same cycle, the flag stays 1. That bit does not count as cleared for R7.
- R9: `rdata_o` shows the byte of flags selected by `addr_i` (0: flags 7..0, 1: flags 15..8), combinationally, with transmit-direction bits forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_done_i | input | 16 | Per-mailbox reception-completed strobe |
| dir_tx_i | input | 16 | Per-mailbox direction, 1 = transmit, 0 = receive |
| mask_i | input | 16 | Per-mailbox interrupt enable, 1 = enabled |
| wr_en_i | input | 1 | CPU write strobe, write-one-to-clear |
| addr_i | input | 1 | Byte select: 0 low byte, 1 high byte |
| wdata_i | input | 8 | CPU write data, ones clear flags |
| rdata_o | output | 8 | Flags of the selected byte |
| irq_o | output | 1 | One-cycle receive interrupt pulse |

## Verification
The bench builds the block with its default parameters: sixteen mailboxes in two byte lanes. With these values both address decodes can be reached, so a clear written to one lane can be checked against flags held in the other lane. Both byte boundaries, flag 0 and flag 15, can be set and cleared. An all-ones receive burst fills both lanes at once. The vector walk covers these cases:
- a first flag raising a pulse;
- later flags raising no pulse;
- masked and transmit-direction mailboxes;
- partial clears and full clears;
- a receive event and a clear in the same cycle, both on different bits and on the same bit.

Directed tests then check the reset state, and reset asserted in the middle of a run while flags are set.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic int unsigned lanes_for(input int unsigned n);
    return (n + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/rxf_flag_bank.sv
module rxf_flag_bank #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] keep_i,
  output logic [N-1:0] flags_o,
  output logic         cleared_any_o,
  output logic         next_nonempty_o
);
  logic [N-1:0] flags_q, flags_d, cleared;

  // set wins over clear; transmit-direction bits are dropped
  always_comb begin
    cleared = clr_i & flags_q & ~set_i & keep_i;
    flags_d = ((flags_q & ~clr_i) | set_i) & keep_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o         = flags_q;
  assign cleared_any_o   = |cleared;
  assign next_nonempty_o = |flags_d;

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

  assert_tx_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keep_i != '1) |=> ((flags_q & ~$past(keep_i)) == '0));

  assert_clear_only_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0 && keep_i == '1) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/rxf_irq_pulse.sv
module rxf_irq_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic was_empty_i,
  input  logic set_any_i,
  input  logic cleared_any_i,
  input  logic next_nonempty_i,
  output logic irq_o
);
  logic fire;

  // one registered bit: several conditions in a cycle merge into one pulse
  assign fire = (was_empty_i & set_any_i) | (cleared_any_i & next_nonempty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= fire;
  end

  assert_no_pulse_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!was_empty_i && !cleared_any_i) |=> !irq_o);

  assert_no_pulse_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_any_i && !cleared_any_i) |=> !irq_o);

  assert_no_pulse_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!next_nonempty_i) |=> !irq_o);
endmodule

// File: rtl/rx_irq_flags.sv
module rx_irq_flags #(
  parameter int unsigned NUM_MBOX = 16,
  localparam int unsigned BW      = rxf_pkg::BYTE_W,
  localparam int unsigned LANES   = rxf_pkg::lanes_for(NUM_MBOX),
  localparam int unsigned ADDR_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_MBOX-1:0] rx_done_i,
  input  logic [NUM_MBOX-1:0] dir_tx_i,
  input  logic [NUM_MBOX-1:0] mask_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BW-1:0]       wdata_i,
  output logic [BW-1:0]       rdata_o,
  output logic                irq_o
);
  localparam int unsigned PAD_W = LANES * BW;

  logic [NUM_MBOX-1:0] set_vec, clr_vec, keep_vec, flags;
  logic [PAD_W-1:0]    clr_pad, flags_pad;
  logic [BW-1:0]       lane_rd [LANES];
  logic                cleared_any, next_nonempty;

  assign keep_vec = ~dir_tx_i;
  assign set_vec  = rx_done_i & mask_i & keep_vec;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign clr_pad[b*BW +: BW] = (wr_en_i && addr_i == ADDR_W'(b)) ? wdata_i : '0;
    assign lane_rd[b]          = flags_pad[b*BW +: BW];
  end

  assign clr_vec   = clr_pad[NUM_MBOX-1:0];
  assign flags_pad = PAD_W'(flags & keep_vec);

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < LANES; b++)
      if (addr_i == ADDR_W'(b)) rdata_o = lane_rd[b];
  end

  rxf_flag_bank #(.N(NUM_MBOX)) u_bank (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .set_i           (set_vec),
    .clr_i           (clr_vec),
    .keep_i          (keep_vec),
    .flags_o         (flags),
    .cleared_any_o   (cleared_any),
    .next_nonempty_o (next_nonempty)
  );

  rxf_irq_pulse u_pulse (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .was_empty_i     (flags == '0),
    .set_any_i       (set_vec != '0),
    .cleared_any_i   (cleared_any),
    .next_nonempty_i (next_nonempty),
    .irq_o           (irq_o)
  );

  assert_irq_has_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags != '0));

  assert_masked_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i == 1'b0) |=> ((flags & ~$past(flags) & ~$past(mask_i)) == '0));
endmodule

// File: tb/rx_irq_flags_tb.sv
`timescale 1ns/100ps
module rx_irq_flags_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] rx_done_i = '0, dir_tx_i = '0, mask_i = '0;
  logic        wr_en_i = 1'b0;
  logic [0:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  rx_irq_flags u_dut (.*);

  typedef struct packed {
    logic [15:0] rx, dir, msk;
    logic        wr, ad;
    logic [7:0]  wd;
    logic [15:0] ef;
    logic        ei;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{16'h0001, 16'h0, 16'hFFFF, 1'b0, 1'b0, 8'h00, 16'h0001, 1'b1, 8'd4},
    '{16'h0000, 16'h0, 16'hFFFF, 1'b0, 1'b0, 8'h00, 16'h0001, 1'b0, 8'd4},
    '{16'h0010, 16'h0, 16'hFFFF, 1'b0, 1'b0, 8'h00, 16'h0011, 1'b0, 8'd5},
    '{16'h0004, 16'h0, 16'hFFFB, 1'b0, 1'b0, 8'h00, 16'h0011, 1'b0, 8'd2},
    '{16'h0000, 16'h0, 16'hFFFF, 1'b1, 1'b0, 8'h01, 16'h0010, 1'b1, 8'd7},
    '{16'h0000, 16'h0, 16'hFFFF, 1'b0, 1'b0, 8'h00, 16'h0010, 1'b0, 8'd7},
    '{16'h0000, 16'h0, 16'hFFFF, 1'b1, 1'b1, 8'hFF, 16'h0010, 1'b0, 8'd6},
    '{16'h0000, 16'h0, 16'hFFFF, 1'b1, 1'b0, 8'h00, 16'h0010, 1'b0, 8'd6},
    '{16'h0000, 16'h0, 16'hFFFF, 1'b1, 1'b0, 8'h10, 16'h0000, 1'b0, 8'd7},
    '{16'h8000, 16'h0, 16'hFFFF, 1'b0, 1'b0, 8'h00, 16'h8000, 1'b1, 8'd2},
    '{16'h0001, 16'h0, 16'hFFFF, 1'b1, 1'b1, 8'h80, 16'h0001, 1'b1, 8'd7},
    '{16'h0001, 16'h0, 16'hFFFF, 1'b1, 1'b0, 8'h01, 16'h0001, 1'b0, 8'd8},
    '{16'h0000, 16'h0001, 16'hFFFF, 1'b0, 1'b0, 8'h00, 16'h0000, 1'b0, 8'd3},
    '{16'h0001, 16'h0001, 16'hFFFF, 1'b0, 1'b0, 8'h00, 16'h0000, 1'b0, 8'd3},
    '{16'h0000, 16'h0, 16'hFFFF, 1'b0, 1'b0, 8'h00, 16'h0000, 1'b0, 8'd3},
    '{16'hFFFF, 16'h0, 16'hFFFF, 1'b0, 1'b0, 8'h00, 16'hFFFF, 1'b1, 8'd9},
    '{16'h0000, 16'h0, 16'hFFFF, 1'b1, 1'b0, 8'hFF, 16'hFF00, 1'b1, 8'd6},
    '{16'h0000, 16'h0, 16'hFFFF, 1'b1, 1'b1, 8'hFF, 16'h0000, 1'b0, 8'd7}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_all(output logic [15:0] v);
    rx_done_i = '0; wr_en_i = 1'b0;
    addr_i = 1'b0; #0.5; v[7:0]  = rdata_o;
    addr_i = 1'b1; #0.5; v[15:8] = rdata_o;
  endtask

  logic [15:0] rd;

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    mask_i = 16'hFFFF;
    #5;
    read_all(rd);
    check("R1 reset flags", rd, 16'h0000);
    check("R1 reset irq", {15'd0, irq_o}, 16'h0000);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      rx_done_i = VEC[i].rx; dir_tx_i = VEC[i].dir; mask_i = VEC[i].msk;
      wr_en_i = VEC[i].wr; addr_i = VEC[i].ad; wdata_i = VEC[i].wd;
      @(posedge clk_i); #0.5;
      check($sformatf("R%0d vec%0d irq", VEC[i].tag, i), {15'd0, irq_o}, {15'd0, VEC[i].ei});
      read_all(rd);
      check($sformatf("R%0d vec%0d flags", VEC[i].tag, i), rd, VEC[i].ef);
    end

    // R9: transmit-direction bits masked on read, combinationally
    @(negedge clk_i);
    dir_tx_i = '0; rx_done_i = 16'h0300;
    @(posedge clk_i); #0.5;
    read_all(rd);
    check("R9 read both lanes", rd, 16'h0300);
    dir_tx_i = 16'h0100; addr_i = 1'b1; #0.5;
    check("R9 tx bit masked on read", {8'd0, rdata_o}, 16'h0002);

    // R1: async reset mid-run clears flags and pulse
    @(negedge clk_i);
    dir_tx_i = '0; rx_done_i = 16'h00F0;
    @(posedge clk_i); #0.5;
    rst_ni = 1'b0; #0.5;
    read_all(rd);
    check("R1 mid-run reset flags", rd, 16'h0000);
    check("R1 mid-run reset irq", {15'd0, irq_o}, 16'h0000);
    @(negedge clk_i); rst_ni = 1'b1;

    // R4: pulse after reset on first flag, one cycle wide
    @(negedge clk_i); rx_done_i = 16'h0080;
    @(posedge clk_i); #0.5;
    check("R4 first flag pulse", {15'd0, irq_o}, 16'h0001);
    rx_done_i = '0;
    @(posedge clk_i); #0.5;
    check("R4 pulse ends", {15'd0, irq_o}, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule